// File: doc/BRIEF.md
# I2C Bus Condition and Fault Monitor

This block watches the two wires of an I2C bus with the system clock. It reports bus conditions as one-cycle pulses: a START, a repeated START, a STOP, and the outcome of each acknowledge slot (ACK or NACK). It also keeps three sticky fault flags. The first flags an SDA level that changes while SCL is high inside a data or acknowledge bit. The second flags SDA pulled low by another device while this node releases it during a bit it is sending. The third flags SCL held low by another device while this node releases the clock, outside the window in which a target may stretch the clock.

The raw line levels, this node's own drive values and the two ownership qualifiers all pass through the same two-flop stage. Because of this, the node's own drive is compared with the bus as it looked at the same moment. An edge is the difference between the current synchronized sample and the previous one. Bits are counted from each START or repeated START. The rising SCL edge that opens slot number `BYTE_BITS+1` is the acknowledge slot. A controller reads the pulses to follow the transfer and reads the flags to detect arbitration or timing faults. It clears the flags with `fault_clear_i`.

Top module: `i2c_line_watch`

## Requirements
- R1: While `rst_ni` is low, and on the first samples after it is released with both lines high, every pulse output and every fault flag is 0.
- R2: With no transfer open, or with a transfer open but no bit yet completed, an SDA fall while SCL stays high on two consecutive samples gives a `start_o` pulse exactly one clock wide. It appears two clock cycles after the edge that first registers the SDA change (the third falling edge after an input change made at a falling edge).
- R3: An SDA fall while SCL is high in the high phase of the first bit slot of a byte, after at least one bit of the transfer has completed, gives a `rstart_o` pulse and no `start_o` pulse. Bit counting restarts.
- R4: An SDA rise while SCL is high, outside slots 2 to 9 of a byte, gives a `stop_o` pulse. The monitor returns to idle, so the next SDA fall with SCL high is reported on `start_o`.
- R5: The 9th SCL rising edge after a START or repeated START, and every 9th one after that, is the acknowledge slot. SDA low at that edge gives an `ack_o` pulse; SDA high gives a `nack_o` pulse. At most one of the five pulse outputs is high in any cycle.
- R6: An SDA change while SCL is high in slots 2 to 9 of a byte (the later data bits and the acknowledge bit) sets `sda_unstable_o` and gives no START, repeated START or STOP pulse.
- R7: An SDA change sampled in the same cycle as an SCL transition is neither a condition nor an instability.
- R8: With `data_owner_i` high and `sda_drive_i` high (released), a sampled SDA low during the SCL-high phase of a bit sets `sda_interf_o`. If this node drives SDA low itself, nothing is flagged.
- R9: With `clk_owner_i` high and `scl_drive_i` high (released), a sampled SCL low sets `scl_interf_o` when it happens outside a transfer or during the high phase of a bit.
- R10: SCL held low during the low phase of a bit inside a transfer (target clock stretching) does not set `scl_interf_o`. No SCL level sets it while `clk_owner_i` is low.
- R11: The fault flags stay set until `fault_clear_i` is high for one cycle, and then read 0 from the next cycle.
- R12: Asserting `rst_ni` in the middle of a transfer clears the flags at once, without a clock edge. After release the monitor is idle, and the next SDA fall with SCL high is a START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_line_i | input | 1 | Raw SCL bus level |
| sda_line_i | input | 1 | Raw SDA bus level |
| scl_drive_i | input | 1 | This node's SCL drive, 1 = released |
| sda_drive_i | input | 1 | This node's SDA drive, 1 = released |
| clk_owner_i | input | 1 | This node generates the clock |
| data_owner_i | input | 1 | This node transmits the current bit |
| fault_clear_i | input | 1 | Clears all fault flags |
| start_o | output | 1 | START pulse |
| rstart_o | output | 1 | Repeated START pulse |
| stop_o | output | 1 | STOP pulse |
| ack_o | output | 1 | Acknowledge slot read low |
| nack_o | output | 1 | Acknowledge slot read high |
| sda_unstable_o | output | 1 | Sticky: SDA moved during SCL high in a bit |
| sda_interf_o | output | 1 | Sticky: SDA pulled low against this node |
| scl_interf_o | output | 1 | Sticky: SCL held low against this node |

## Verification
A wrong bit count shows within one byte. The acknowledge pulse lands on the wrong rising edge, or a STOP that follows the acknowledge is read as an instability with no `stop_o` pulse. The byte sweep therefore compares the ACK, NACK and condition counts after every byte pattern. A wrong phase or stale transfer state shows as a START reported where a repeated START was due, or as a fault flag rising during legal clock stretching. Both are visible two cycles after the line edge concerned. Misaligned drive and bus delays show as spurious interference flags on the first clock edge of ordinary traffic.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

  typedef enum logic [1:0] {
    PH_LOW   = 2'd0,  // SCL low, between bits
    PH_FREE  = 2'd1,  // SCL high, not part of a counted bit
    PH_FIRST = 2'd2,  // SCL high, first slot of a byte
    PH_DATA  = 2'd3   // SCL high, later data bit or acknowledge slot
  } phase_e;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic ack;
    logic nack;
  } evt_t;

  typedef struct packed {
    logic unstable;
    logic sda_intf;
    logic scl_intf;
  } fault_t;

endpackage

// File: rtl/i2c_watch_sync.sv
module i2c_watch_sync #(
  parameter int unsigned       WIDTH   = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;

    if (s == 0) begin : g_head
      assign stage_d = d_i;
    end else begin : g_tail
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= RST_VAL;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_watch_cond.sv
module i2c_watch_cond
  import i2c_watch_pkg::*;
#(
  parameter int unsigned BYTE_BITS = 8,
  localparam int unsigned CNT_W    = $clog2(BYTE_BITS + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   scl_i,
  input  logic   sda_i,
  output logic   scl_prev_o,
  output logic   sda_prev_o,
  output phase_e phase_o,
  output logic   active_o,
  output evt_t   evt_o
);

  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_BITS);

  logic             scl_prev_q, sda_prev_q;
  phase_e           phase_q, phase_d;
  logic             active_q, active_d;
  logic             xfer_q, xfer_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  evt_t             evt_q, evt_d;

  logic scl_rise, scl_fall, scl_hi, sda_fall, sda_rise, cond_ok;

  assign scl_rise = !scl_prev_q && scl_i;
  assign scl_fall = scl_prev_q && !scl_i;
  assign scl_hi   = scl_prev_q && scl_i;
  assign sda_fall = sda_prev_q && !sda_i;
  assign sda_rise = !sda_prev_q && sda_i;
  assign cond_ok  = (phase_q != PH_DATA);

  always_comb begin
    phase_d  = phase_q;
    active_d = active_q;
    xfer_d   = xfer_q;
    cnt_d    = cnt_q;
    evt_d    = '0;

    if (scl_rise) begin
      if (active_q) begin
        phase_d = (cnt_q == '0) ? PH_FIRST : PH_DATA;
        if (cnt_q == ACK_SLOT) begin
          evt_d.ack  = !sda_i;
          evt_d.nack = sda_i;
          cnt_d      = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else begin
        phase_d = PH_FREE;
      end
    end else if (scl_fall) begin
      if (phase_q == PH_FIRST || phase_q == PH_DATA) begin
        xfer_d = 1'b1;
      end
      phase_d = PH_LOW;
    end else if (scl_hi && cond_ok) begin
      if (sda_fall) begin
        evt_d.rstart = active_q && xfer_q;
        evt_d.start  = !(active_q && xfer_q);
        active_d     = 1'b1;
        xfer_d       = 1'b0;
        cnt_d        = '0;
        phase_d      = PH_FREE;
      end else if (sda_rise) begin
        evt_d.stop = 1'b1;
        active_d   = 1'b0;
        xfer_d     = 1'b0;
        cnt_d      = '0;
        phase_d    = PH_FREE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
      phase_q    <= PH_FREE;
      active_q   <= 1'b0;
      xfer_q     <= 1'b0;
      cnt_q      <= '0;
      evt_q      <= '0;
    end else begin
      scl_prev_q <= scl_i;
      sda_prev_q <= sda_i;
      phase_q    <= phase_d;
      active_q   <= active_d;
      xfer_q     <= xfer_d;
      cnt_q      <= cnt_d;
      evt_q      <= evt_d;
    end
  end

  assign scl_prev_o = scl_prev_q;
  assign sda_prev_o = sda_prev_q;
  assign phase_o    = phase_q;
  assign active_o   = active_q;
  assign evt_o      = evt_q;

endmodule

// File: rtl/i2c_watch_fault.sv
module i2c_watch_fault
  import i2c_watch_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   scl_i,
  input  logic   sda_i,
  input  logic   scl_prev_i,
  input  logic   sda_prev_i,
  input  phase_e phase_i,
  input  logic   active_i,
  input  logic   scl_rel_i,
  input  logic   sda_rel_i,
  input  logic   clk_own_i,
  input  logic   data_own_i,
  input  logic   clear_i,
  output fault_t flags_o
);

  fault_t flags_q, flags_d, hit;
  logic   scl_hi, in_bit, stretch_ok;

  assign scl_hi     = scl_prev_i && scl_i;
  assign in_bit     = (phase_i == PH_FIRST) || (phase_i == PH_DATA);
  assign stretch_ok = active_i && (phase_i == PH_LOW);

  always_comb begin
    hit          = '0;
    hit.unstable = scl_hi && (phase_i == PH_DATA) && (sda_i != sda_prev_i);
    hit.sda_intf = data_own_i && sda_rel_i && scl_hi && in_bit && !sda_i;
    hit.scl_intf = clk_own_i && scl_rel_i && !scl_i && !stretch_ok;
    flags_d      = (clear_i ? fault_t'('0) : flags_q) | hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/i2c_line_watch.sv
module i2c_line_watch
  import i2c_watch_pkg::*;
#(
  parameter int unsigned BYTE_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_line_i,
  input  logic sda_line_i,
  input  logic scl_drive_i,
  input  logic sda_drive_i,
  input  logic clk_owner_i,
  input  logic data_owner_i,
  input  logic fault_clear_i,
  output logic start_o,
  output logic rstart_o,
  output logic stop_o,
  output logic ack_o,
  output logic nack_o,
  output logic sda_unstable_o,
  output logic sda_interf_o,
  output logic scl_interf_o
);

  localparam int unsigned     LANES    = 6;
  localparam logic [LANES-1:0] LANE_RST = 6'b00_1111;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n = rst_pipe_q[1];

  // Bus levels and own drive travel through the same stages to stay aligned.
  logic [LANES-1:0] lane_raw, lane_s;

  assign lane_raw = {data_owner_i, clk_owner_i, sda_drive_i, scl_drive_i,
                     sda_line_i, scl_line_i};

  i2c_watch_sync #(
    .WIDTH  (LANES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LANE_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (lane_raw),
    .q_o   (lane_s)
  );

  logic   scl_prev, sda_prev, active;
  phase_e phase;
  evt_t   evt;
  fault_t flags;

  i2c_watch_cond #(
    .BYTE_BITS(BYTE_BITS)
  ) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .scl_i     (lane_s[0]),
    .sda_i     (lane_s[1]),
    .scl_prev_o(scl_prev),
    .sda_prev_o(sda_prev),
    .phase_o   (phase),
    .active_o  (active),
    .evt_o     (evt)
  );

  i2c_watch_fault u_fault (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .scl_i     (lane_s[0]),
    .sda_i     (lane_s[1]),
    .scl_prev_i(scl_prev),
    .sda_prev_i(sda_prev),
    .phase_i   (phase),
    .active_i  (active),
    .scl_rel_i (lane_s[2]),
    .sda_rel_i (lane_s[3]),
    .clk_own_i (lane_s[4]),
    .data_own_i(lane_s[5]),
    .clear_i   (fault_clear_i),
    .flags_o   (flags)
  );

  assign start_o        = evt.start;
  assign rstart_o       = evt.rstart;
  assign stop_o         = evt.stop;
  assign ack_o          = evt.ack;
  assign nack_o         = evt.nack;
  assign sda_unstable_o = flags.unstable;
  assign sda_interf_o   = flags.sda_intf;
  assign scl_interf_o   = flags.scl_intf;

endmodule

// File: rtl/i2c_line_watch_chk.sv
module i2c_line_watch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_owner_i,
  input logic data_owner_i,
  input logic fault_clear_i,
  input logic start_o,
  input logic rstart_o,
  input logic stop_o,
  input logic ack_o,
  input logic nack_o,
  input logic sda_unstable_o,
  input logic sda_interf_o,
  input logic scl_interf_o
);

  // Transfer window as seen from the pulse outputs alone.
  logic open_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
    end else if (start_o) begin
      open_q <= 1'b1;
    end else if (stop_o) begin
      open_q <= 1'b0;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R2

  AST_RSTART_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstart_o |-> open_q); // R3

  AST_EVENTS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, rstart_o, stop_o, ack_o, nack_o})); // R5

  AST_UNSTABLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_unstable_o && !fault_clear_i |=> sda_unstable_o); // R11

  AST_SDA_INTF_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_interf_o) |-> $past(data_owner_i, 2)); // R8

  AST_SCL_INTF_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_interf_o) |-> $past(clk_owner_i, 2)); // R9

endmodule

bind i2c_line_watch i2c_line_watch_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clk_owner_i   (clk_owner_i),
  .data_owner_i  (data_owner_i),
  .fault_clear_i (fault_clear_i),
  .start_o       (start_o),
  .rstart_o      (rstart_o),
  .stop_o        (stop_o),
  .ack_o         (ack_o),
  .nack_o        (nack_o),
  .sda_unstable_o(sda_unstable_o),
  .sda_interf_o  (sda_interf_o),
  .scl_interf_o  (scl_interf_o)
);

// File: tb/i2c_line_watch_tb.sv
module i2c_line_watch_tb;

  localparam int HP = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic h_scl = 1'b1, h_sda = 1'b1, t_scl = 1'b1, t_sda = 1'b1;
  logic hm = 1'b1, tx = 1'b0, clr = 1'b0;

  logic start_o, rstart_o, stop_o, ack_o, nack_o;
  logic unst_o, sdai_o, scli_o;

  i2c_line_watch u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .scl_line_i    (h_scl & t_scl),
    .sda_line_i    (h_sda & t_sda),
    .scl_drive_i   (h_scl),
    .sda_drive_i   (h_sda),
    .clk_owner_i   (hm),
    .data_owner_i  (tx),
    .fault_clear_i (clr),
    .start_o       (start_o),
    .rstart_o      (rstart_o),
    .stop_o        (stop_o),
    .ack_o         (ack_o),
    .nack_o        (nack_o),
    .sda_unstable_o(unst_o),
    .sda_interf_o  (sdai_o),
    .scl_interf_o  (scli_o)
  );

  int n_checks = 0, n_fail = 0, wide = 0;
  int got [5];
  int exp_c [5];
  logic [4:0] prev_ev = '0;
  bit done = 0;

  // Pulse monitor: index 0 start, 1 rstart, 2 stop, 3 ack, 4 nack
  always @(negedge clk) begin
    logic [4:0] ev;
    ev = {nack_o, ack_o, stop_o, rstart_o, start_o};
    if (rst_n) begin
      for (int k = 0; k < 5; k++) begin
        if (ev[k]) got[k]++;
        if (ev[k] && prev_ev[k]) wide++;
      end
    end
    prev_ev = ev;
  end

  task automatic chk(input string tag, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    wait_clk(6);
    #1;
  endtask

  task automatic chk_counts(input string where);
    chk({"R2 start count ", where},  got[0], exp_c[0]);
    chk({"R3 rstart count ", where}, got[1], exp_c[1]);
    chk({"R4 stop count ", where},   got[2], exp_c[2]);
    chk({"R5 ack count ", where},    got[3], exp_c[3]);
    chk({"R5 nack count ", where},   got[4], exp_c[4]);
  endtask

  task automatic clear_flags();
    clr = 1'b1;
    wait_clk(1);
    clr = 1'b0;
    wait_clk(1);
    #1;
  endtask

  // mode: 0 plain, 1 host glitch in high phase, 2 target glitch, 3 SDA flips with SCL fall
  task automatic drive_bit(input logic hb, input logic tb, input logic txv, input int mode);
    h_sda = hb; t_sda = tb; tx = txv;
    wait_clk(HP);
    h_scl = 1'b1;
    if (mode == 1 || mode == 2) begin
      wait_clk(1);
      if (mode == 1) h_sda = ~hb; else t_sda = ~tb;
      wait_clk(1);
      if (mode == 1) h_sda = hb; else t_sda = tb;
      wait_clk(HP - 2);
    end else begin
      wait_clk(HP);
    end
    h_scl = 1'b0;
    if (mode == 3) h_sda = ~hb;
    wait_clk(HP);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit host_tx, input logic ackv);
    for (int i = 7; i >= 0; i--) begin
      if (host_tx) drive_bit(v[i], 1'b1, 1'b1, 0);
      else         drive_bit(1'b1, v[i], 1'b0, 0);
    end
    if (host_tx) drive_bit(1'b1, ackv, 1'b0, 0);
    else         drive_bit(ackv, 1'b1, 1'b1, 0);
    if (ackv) exp_c[4]++; else exp_c[3]++;
  endtask

  task automatic bus_start();
    h_sda = 1'b0; wait_clk(HP);
    h_scl = 1'b0; wait_clk(HP);
    exp_c[0]++;
  endtask

  task automatic bus_rstart();
    h_sda = 1'b1; t_sda = 1'b1; tx = 1'b0; wait_clk(HP);
    h_scl = 1'b1; wait_clk(HP);
    h_sda = 1'b0; wait_clk(HP);
    h_scl = 1'b0; wait_clk(HP);
    exp_c[1]++;
  endtask

  task automatic bus_stop();
    h_sda = 1'b0; t_sda = 1'b1; tx = 1'b0; wait_clk(HP);
    h_scl = 1'b1; wait_clk(HP);
    h_sda = 1'b1; wait_clk(2 * HP);
    exp_c[2]++;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    for (int k = 0; k < 5; k++) begin got[k] = 0; exp_c[k] = 0; end
    wait_clk(5);
    #1;
    // R1: reset state
    chk("R1 pulses in reset", {start_o, rstart_o, stop_o, ack_o, nack_o}, 0);
    chk("R1 flags in reset", {unst_o, sdai_o, scli_o}, 0);
    rst_n = 1'b1;
    wait_clk(6);
    #1;
    chk("R1 flags after release", {unst_o, sdai_o, scli_o}, 0);

    // R2: START latency and width
    begin
      logic [3:0] seen;
      h_sda = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); #1;
        seen[i] = start_o;
      end
      chk("R2 start pulse timing", int'(seen), 4'b0100);
      h_scl = 1'b0; wait_clk(HP);
      exp_c[0]++;
    end

    // R5 sweep over all byte values, both directions, repeated STARTs (R3)
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v), !v[1], v[0]);
      if (v == 63 || v == 127 || v == 191) bus_rstart();
    end
    bus_stop();
    settle();
    chk_counts("after sweep");
    chk("R6 no instability in clean traffic", unst_o, 0);
    chk("R8 no sda interference in clean traffic", sdai_o, 0);
    chk("R10 no scl interference in clean traffic", scli_o, 0);

    // R4: after STOP a new fall is a START, and STOP right after an acknowledge
    bus_start();
    send_byte(8'hA5, 1'b1, 1'b0);
    bus_stop();
    settle();
    chk_counts("R4 restart after stop");

    // R7: simultaneous SDA/SCL edges
    h_sda = 1'b0; h_scl = 1'b0; wait_clk(HP);
    h_sda = 1'b1; h_scl = 1'b1; wait_clk(HP);
    settle();
    chk_counts("R7 idle skew");
    bus_start();
    drive_bit(1'b1, 1'b1, 1'b1, 0);
    drive_bit(1'b0, 1'b1, 1'b1, 0);
    drive_bit(1'b1, 1'b1, 1'b1, 3);
    for (int i = 0; i < 5; i++) drive_bit(1'b0, 1'b1, 1'b1, 3);
    drive_bit(1'b1, 1'b0, 1'b0, 0);
    exp_c[3]++;
    bus_stop();
    settle();
    chk_counts("R7 in-transfer skew");
    chk("R7 no instability on skewed edges", unst_o, 0);

    // R6: glitch in a data bit, then in an acknowledge slot
    bus_start();
    send_byte(8'h42, 1'b1, 1'b0);
    drive_bit(1'b1, 1'b1, 1'b0, 0);
    drive_bit(1'b1, 1'b0, 1'b0, 0);
    drive_bit(1'b1, 1'b1, 1'b0, 2);
    settle();
    chk("R6 unstable in data bit", unst_o, 1);
    for (int i = 0; i < 5; i++) drive_bit(1'b1, 1'b1, 1'b0, 0);
    drive_bit(1'b0, 1'b1, 1'b1, 1);
    exp_c[3]++;
    settle();
    chk_counts("R6 no conditions from glitches");
    chk("R11 flag still set", unst_o, 1);
    clear_flags();
    chk("R11 flag cleared", unst_o, 0);
    send_byte(8'h00, 1'b0, 1'b0);
    drive_bit(1'b1, 1'b1, 1'b0, 0);
    for (int i = 0; i < 7; i++) drive_bit(1'b1, 1'b1, 1'b0, 0);
    drive_bit(1'b0, 1'b1, 1'b1, 1);
    exp_c[3]++;
    settle();
    chk("R6 unstable in acknowledge slot", unst_o, 1);
    bus_stop();
    clear_flags();

    // R8: SDA interference
    bus_start();
    drive_bit(1'b0, 1'b0, 1'b1, 0);
    settle();
    chk("R8 no flag when own drive is low", sdai_o, 0);
    drive_bit(1'b1, 1'b0, 1'b1, 0);
    settle();
    chk("R8 flag when released SDA reads low", sdai_o, 1);
    chk("R6 steady low bit is not instability", unst_o, 0);
    for (int i = 0; i < 6; i++) drive_bit(1'b1, 1'b1, 1'b1, 0);
    drive_bit(1'b1, 1'b0, 1'b0, 0);
    exp_c[3]++;
    bus_stop();
    settle();
    chk_counts("R8 transfer");
    clear_flags();
    chk("R11 sda interference cleared", sdai_o, 0);

    // R10: target stretches during the low phase
    bus_start();
    tx = 1'b1; h_sda = 1'b1; t_scl = 1'b0;
    wait_clk(HP);
    h_scl = 1'b1;
    wait_clk(6);
    t_scl = 1'b1;
    wait_clk(HP);
    h_scl = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < 7; i++) drive_bit(1'b1, 1'b1, 1'b1, 0);
    drive_bit(1'b1, 1'b1, 1'b0, 0);
    exp_c[4]++;
    bus_stop();
    settle();
    chk("R10 stretch in low phase not flagged", scli_o, 0);
    chk_counts("R10 transfer");

    hm = 1'b0;
    t_scl = 1'b0; wait_clk(HP);
    t_scl = 1'b1;
    settle();
    chk("R10 no flag without clock ownership", scli_o, 0);
    hm = 1'b1;
    wait_clk(4);

    // R9: SCL held low while idle and owned
    t_scl = 1'b0; wait_clk(HP);
    t_scl = 1'b1;
    settle();
    chk("R9 idle SCL pulled low", scli_o, 1);
    clear_flags();
    chk("R11 scl interference cleared", scli_o, 0);

    // R9 during a bit's high phase, then R12 asynchronous reset
    bus_start();
    tx = 1'b1; h_sda = 1'b1;
    wait_clk(HP);
    h_scl = 1'b1;
    wait_clk(2);
    t_scl = 1'b0;
    wait_clk(2);
    t_scl = 1'b1;
    settle();
    chk("R9 SCL pulled low in high phase", scli_o, 1);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R12 flags cleared by reset without clock", {unst_o, sdai_o, scli_o}, 0);
    h_scl = 1'b1; h_sda = 1'b1; t_scl = 1'b1; t_sda = 1'b1; tx = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(6);
    bus_start();
    wait_clk(HP);
    bus_stop();
    settle();
    chk_counts("R12 after reset");

    chk("R2 every pulse one cycle wide", wide, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule